// File: doc/BRIEF.md
# Banked Memory Address Decoder

This decoder lets a processor with a 16-bit data address space reach a larger external SRAM, 128K or 512K bytes, through 32K-byte banks. The processor's low 15 address lines go straight to the SRAM. The decoder supplies the upper SRAM address lines, the SRAM chip select, and a chip select for an optional UART register file. The lower 32K of the processor space is always bank 0. The upper 32K is steered by a programmable upper-window bank register.

A second bank register applies to every read made while the processor's DMA flag is set, in either half of the space. Both registers are loaded by writes made while the DMA flag is set. The register is chosen by data bits 5:4, not by address, and data bits 3:0 carry the bank number. When the upper-window bank is 0, the upper half of the space maps onto the UART instead of RAM.

The parameter `WIDE` picks the variant. `WIDE=1` gives four bank bits and 512K of SRAM. `WIDE=0` gives two bank bits and 128K of SRAM; in that variant DMA reads always use bank 1.

Top module: `bank_addr_dec`

## Requirements
- R1: With neither the read nor the write strobe asserted, both chip selects are low.
- R2: A non-DMA access with address bit 15 = 0 selects the SRAM with upper address bits 0, whatever the bank registers hold.
- R3: A non-DMA access with address bit 15 = 1 selects the SRAM with upper address bits equal to the upper-window bank register, unless R6 applies.
- R4: In the wide variant, a read with the DMA flag set selects the SRAM with upper bits equal to the DMA bank register. This holds in either address half, and even when the upper-window bank is 0.
- R5: A write with the DMA flag set loads data bits 3:0 into a bank register from the next cycle. Data bits 5:4 = 01 select the upper-window register and 11 select the DMA register.
- R6: A non-DMA access with address bit 15 = 1 while the upper-window bank is 0 asserts the UART chip select and leaves the SRAM deselected; the upper bits then read 0.
- R7: A DMA-flagged write with data bit 4 = 0 is a colour-map write. It leaves both bank registers unchanged.
- R8: Reset (rst_ni low) sets both bank registers to 1.
- R9: During a write with the DMA flag set, neither chip select is asserted.
- R10: In the narrow variant, only bits 1:0 of a written bank value are kept, so 0xC counts as bank 0. DMA reads use bank 1, and DMA-register writes have no effect.
- R11: The SRAM and UART chip selects are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Processor data address |
| data_i | input | 8 | Processor write data |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| dma_i | input | 1 | DMA flag from the processor |
| sram_hi_o | output | 4 (WIDE=1) / 2 | Upper SRAM address bits |
| sram_cs_o | output | 1 | SRAM chip select, active high |
| uart_cs_o | output | 1 | UART chip select, active high |

## Verification
A write with the DMA flag set is a register load in its own cycle. It also decides which bank the very next access sees. The bench therefore follows each register-loading write with a read in the following cycle. It checks that the write itself selects nothing and that the read's upper bits and chip select already reflect the new value.

Colour-map writes are mixed into the same stream. Both variants run side by side, so one pattern, such as writing bank 0xC, can be judged as RAM in one variant and as the UART in the other.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  typedef enum logic [1:0] {
    WSEL_NONE  = 2'd0,
    WSEL_UPPER = 2'd1,
    WSEL_DMA   = 2'd2
  } wsel_e;

  localparam int unsigned BANK_VAL_W = 4;

  function automatic wsel_e decode_sel(input logic [1:0] f);
    case (f)
      2'b01:   return WSEL_UPPER;
      2'b11:   return WSEL_DMA;
      default: return WSEL_NONE;   // bit4 = 0 -> colour map
    endcase
  endfunction
endpackage

// File: rtl/bank_wr_decode.sv
module bank_wr_decode
  import bank_dec_pkg::*;
(
  input  logic                  wr_i,
  input  logic                  dma_i,
  input  logic [5:0]            cmd_i,
  output logic                  upper_we_o,
  output logic                  dma_we_o,
  output logic [BANK_VAL_W-1:0] val_o
);
  wsel_e sel;

  always_comb begin
    sel        = decode_sel(cmd_i[5:4]);
    upper_we_o = wr_i && dma_i && (sel == WSEL_UPPER);
    dma_we_o   = wr_i && dma_i && (sel == WSEL_DMA);
    val_o      = cmd_i[3:0];
  end
endmodule

// File: rtl/bank_regs.sv
module bank_regs
  import bank_dec_pkg::*;
#(
  parameter bit WIDE = 1'b1,
  localparam int unsigned BW = WIDE ? 4 : 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  upper_we_i,
  input  logic                  dma_we_i,
  input  logic [BANK_VAL_W-1:0] val_i,
  output logic [BW-1:0]         upper_bank_o,
  output logic [BW-1:0]         dma_bank_o
);
  localparam logic [BW-1:0] BANK_RST = BW'(1);

  logic [BW-1:0] upper_q;
  logic [BW-1:0] dma_q;
  logic          unused_val;

  assign unused_val = ^val_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         upper_q <= BANK_RST;
    else if (upper_we_i) upper_q <= val_i[BW-1:0];
  end

  generate
    if (WIDE) begin : g_dma_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       dma_q <= BANK_RST;
        else if (dma_we_i) dma_q <= val_i[BW-1:0];
      end
    end else begin : g_dma_fixed
      logic unused_we;
      assign unused_we = dma_we_i;
      assign dma_q     = BANK_RST;   // narrow: DMA always bank 1
    end
  endgenerate

  assign upper_bank_o = upper_q;
  assign dma_bank_o   = dma_q;
endmodule

// File: rtl/bank_route.sv
module bank_route #(
  parameter int unsigned BW = 4
) (
  input  logic          addr_hi_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          dma_i,
  input  logic [BW-1:0] upper_bank_i,
  input  logic [BW-1:0] dma_bank_i,
  output logic [BW-1:0] hi_o,
  output logic          sram_cs_o,
  output logic          uart_cs_o
);
  logic access, reg_wr, uart_hit;

  always_comb begin
    access   = rd_i || wr_i;
    reg_wr   = wr_i && dma_i;
    uart_hit = access && !dma_i && addr_hi_i && (upper_bank_i == '0);
    if (dma_i)          hi_o = dma_bank_i;
    else if (addr_hi_i) hi_o = upper_bank_i;
    else                hi_o = '0;
    sram_cs_o = access && !reg_wr && !uart_hit;
    uart_cs_o = uart_hit;
  end
endmodule

// File: rtl/bank_addr_dec.sv
module bank_addr_dec
  import bank_dec_pkg::*;
#(
  parameter bit WIDE = 1'b1,
  localparam int unsigned BW = WIDE ? 4 : 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [15:0]   addr_i,
  input  logic [7:0]    data_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          dma_i,
  output logic [BW-1:0] sram_hi_o,
  output logic          sram_cs_o,
  output logic          uart_cs_o
);
  logic                  upper_we, dma_we;
  logic [BANK_VAL_W-1:0] bank_val;
  logic [BW-1:0]         upper_bank, dma_bank;
  logic                  unused_bus;

  assign unused_bus = ^{addr_i[14:0], data_i[7:6]};  // low address goes straight to SRAM

  bank_wr_decode u_dec (
    .wr_i       (wr_i),
    .dma_i      (dma_i),
    .cmd_i      (data_i[5:0]),
    .upper_we_o (upper_we),
    .dma_we_o   (dma_we),
    .val_o      (bank_val)
  );

  bank_regs #(.WIDE(WIDE)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .upper_we_i   (upper_we),
    .dma_we_i     (dma_we),
    .val_i        (bank_val),
    .upper_bank_o (upper_bank),
    .dma_bank_o   (dma_bank)
  );

  bank_route #(.BW(BW)) u_route (
    .addr_hi_i    (addr_i[15]),
    .rd_i         (rd_i),
    .wr_i         (wr_i),
    .dma_i        (dma_i),
    .upper_bank_i (upper_bank),
    .dma_bank_i   (dma_bank),
    .hi_o         (sram_hi_o),
    .sram_cs_o    (sram_cs_o),
    .uart_cs_o    (uart_cs_o)
  );
endmodule

// File: rtl/bank_addr_dec_chk.sv
module bank_addr_dec_chk #(
  parameter int unsigned BW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          addr_hi_i,
  input logic [5:0]    cmd_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic          dma_i,
  input logic [BW-1:0] hi_i,
  input logic          sram_cs_i,
  input logic          uart_cs_i,
  input logic [BW-1:0] upper_q_i
);
  p_cs_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_cs_i && uart_cs_i));

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |-> !sram_cs_i && !uart_cs_i);

  p_low_half_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) && !dma_i && !addr_hi_i |-> sram_cs_i && hi_i == '0);

  p_regwr_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && dma_i |-> !sram_cs_i && !uart_cs_i);

  p_upper_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && dma_i && cmd_i[5:4] == 2'b01 |=> upper_q_i == $past(cmd_i[BW-1:0]));

  p_colour_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && dma_i && !cmd_i[4] |=> $stable(upper_q_i));

  p_uart_map_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) && !dma_i && addr_hi_i && upper_q_i == '0 |-> uart_cs_i && !sram_cs_i);
endmodule

bind bank_addr_dec bank_addr_dec_chk #(.BW(BW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_hi_i (addr_i[15]),
  .cmd_i     (data_i[5:0]),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .dma_i     (dma_i),
  .hi_i      (sram_hi_o),
  .sram_cs_i (sram_cs_o),
  .uart_cs_i (uart_cs_o),
  .upper_q_i (upper_bank)
);

// File: tb/bank_addr_dec_test.sv
`timescale 1ns/1ps
module bank_addr_dec_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        rd = 1'b0, wr = 1'b0, dma = 1'b0;
  logic [3:0]  hi_w;
  logic [1:0]  hi_n;
  logic        sram_w, uart_w, sram_n, uart_n;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  bank_addr_dec #(.WIDE(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .data_i(data),
    .rd_i(rd), .wr_i(wr), .dma_i(dma),
    .sram_hi_o(hi_w), .sram_cs_o(sram_w), .uart_cs_o(uart_w));

  bank_addr_dec #(.WIDE(1'b0)) uut_nar (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .data_i(data),
    .rd_i(rd), .wr_i(wr), .dma_i(dma),
    .sram_hi_o(hi_n), .sram_cs_o(sram_n), .uart_cs_o(uart_n));

  // {req4, op2 (0 idle,1 rd,2 wr), dma, addr16, data8, exp_hi4, exp_sram, exp_uart}
  localparam int N = 21;
  localparam logic [36:0] VEC [N] = '{
    {4'd2,  2'd1, 1'b0, 16'h1234, 8'h00, 4'h0, 1'b1, 1'b0},
    {4'd8,  2'd1, 1'b0, 16'h8000, 8'h00, 4'h1, 1'b1, 1'b0},
    {4'd9,  2'd2, 1'b1, 16'h0000, 8'h15, 4'h1, 1'b0, 1'b0},
    {4'd3,  2'd1, 1'b0, 16'h9000, 8'h00, 4'h5, 1'b1, 1'b0},
    {4'd2,  2'd1, 1'b0, 16'h0100, 8'h00, 4'h0, 1'b1, 1'b0},
    {4'd5,  2'd2, 1'b1, 16'h0000, 8'h3A, 4'h1, 1'b0, 1'b0},
    {4'd4,  2'd1, 1'b1, 16'h8004, 8'h00, 4'hA, 1'b1, 1'b0},
    {4'd4,  2'd1, 1'b1, 16'h0004, 8'h00, 4'hA, 1'b1, 1'b0},
    {4'd7,  2'd2, 1'b1, 16'h0000, 8'h2F, 4'hA, 1'b0, 1'b0},
    {4'd7,  2'd1, 1'b0, 16'h8000, 8'h00, 4'h5, 1'b1, 1'b0},
    {4'd7,  2'd2, 1'b1, 16'h0000, 8'h0F, 4'hA, 1'b0, 1'b0},
    {4'd7,  2'd1, 1'b1, 16'h8000, 8'h00, 4'hA, 1'b1, 1'b0},
    {4'd5,  2'd2, 1'b1, 16'h0000, 8'h10, 4'hA, 1'b0, 1'b0},
    {4'd6,  2'd1, 1'b0, 16'h8000, 8'h00, 4'h0, 1'b0, 1'b1},
    {4'd6,  2'd2, 1'b0, 16'hFFFF, 8'h55, 4'h0, 1'b0, 1'b1},
    {4'd2,  2'd1, 1'b0, 16'h7FFF, 8'h00, 4'h0, 1'b1, 1'b0},
    {4'd4,  2'd1, 1'b1, 16'h8000, 8'h00, 4'hA, 1'b1, 1'b0},
    {4'd1,  2'd0, 1'b0, 16'h8000, 8'h00, 4'h0, 1'b0, 1'b0},
    {4'd1,  2'd0, 1'b1, 16'h0000, 8'h00, 4'hA, 1'b0, 1'b0},
    {4'd5,  2'd2, 1'b1, 16'h0000, 8'h1C, 4'hA, 1'b0, 1'b0},
    {4'd3,  2'd2, 1'b0, 16'hC000, 8'h77, 4'hC, 1'b1, 1'b0}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic d, input logic [15:0] a, input logic [7:0] v);
    @(negedge clk);
    rd = (op == 2'd1); wr = (op == 2'd2); dma = d; addr = a; data = v;
    #1;
  endtask

  initial begin
    #160000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", "reset sram_cs", int'(sram_w), 0);
    check("R1", "reset uart_cs", int'(uart_w), 0);
    @(negedge clk) rst_ni = 1'b1;

    for (int i = 0; i < N; i++) begin
      drive(VEC[i][32:31], VEC[i][30], VEC[i][29:14], VEC[i][13:6]);
      check($sformatf("R%0d", VEC[i][36:33]), $sformatf("vec%0d hi", i), int'(hi_w), int'(VEC[i][5:2]));
      check($sformatf("R%0d", VEC[i][36:33]), $sformatf("vec%0d sram_cs", i), int'(sram_w), int'(VEC[i][1]));
      check($sformatf("R%0d", VEC[i][36:33]), $sformatf("vec%0d uart_cs", i), int'(uart_w), int'(VEC[i][0]));
      check("R11", "exclusive cs", int'(sram_w & uart_w), 0);
    end

    // R10: narrow kept only bits 1:0 of 0x1C -> bank 0 -> UART
    drive(2'd1, 1'b0, 16'h8000, 8'h00);
    check("R10", "narrow uart_cs bank C", int'(uart_n), 1);
    check("R10", "narrow sram_cs bank C", int'(sram_n), 0);
    check("R3", "wide hi bank C", int'(hi_w), 4'hC);
    // R10: DMA reads forced to bank 1 in narrow
    drive(2'd1, 1'b1, 16'h8000, 8'h00);
    check("R10", "narrow dma hi", int'(hi_n), 1);
    check("R4", "wide dma hi", int'(hi_w), 4'hA);
    // R10: DMA register write ignored in narrow
    drive(2'd2, 1'b1, 16'h0000, 8'h33);
    drive(2'd1, 1'b1, 16'h0000, 8'h00);
    check("R10", "narrow dma write ignored", int'(hi_n), 1);
    check("R5", "wide dma bank 3", int'(hi_w), 3);
    drive(2'd2, 1'b1, 16'h0000, 8'h16);
    drive(2'd1, 1'b0, 16'h8000, 8'h00);
    check("R10", "narrow upper bank 2", int'(hi_n), 2);
    check("R10", "narrow sram_cs", int'(sram_n), 1);
    check("R3", "wide upper bank 6", int'(hi_w), 6);

    // R8: reset mid-run restores bank 1 in both registers
    @(negedge clk) begin rst_ni = 1'b0; rd = 1'b0; wr = 1'b0; dma = 1'b0; end
    @(negedge clk) rst_ni = 1'b1;
    drive(2'd1, 1'b0, 16'h8000, 8'h00);
    check("R8", "wide upper after reset", int'(hi_w), 1);
    check("R8", "narrow upper after reset", int'(hi_n), 1);
    drive(2'd1, 1'b1, 16'h0000, 8'h00);
    check("R8", "wide dma after reset", int'(hi_w), 1);
    check("R4", "dma read sram_cs", int'(sram_w), 1);
    drive(2'd0, 1'b0, 16'h0000, 8'h00);
    check("R1", "final idle sram_cs", int'(sram_w), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule